// File: doc/BRIEF.md
# Tick-Synchronized RTC Register Front End

This block sits between a simple host register bus and the time-keeping core of a low-speed real-time clock. Writes to the time, alarm, interrupt-enable and prescaler-enable registers are not applied when the host issues them. The block holds each such write and commits it on the next clock tick. While a commit is outstanding, the status register shows a pending flag. When the commit lands, a completion flag is raised. If the host writes again before the commit, that second write is lost. The host should therefore poll the pending flag before it writes.

The status register is the only register that skips the tick wait. Writing ones to it clears the matching bits in the next host cycle. Event pulses from the time-keeping core set status bits whether or not their enables are set. The interrupt request is registered on the host clock and is active when any status bit is set together with its enable bit. The tick that commits a write depends on the committed prescaler bit. With the prescaler enabled, the once-per-second tick is used. With it disabled, the raw oscillator tick is used.

Top module: `rtc_sync_regs`

## Requirements
- R1: After reset, the time, alarm, enable and prescaler registers read 0, every status bit reads 0, no write is pending, `irq_o` and `time_load_o` are 0.
- R2: A host write to address 1 (enable), 2 (time), 3 (alarm) or 4 (prescaler) that is accepted leaves every register output unchanged, and status bit 14 reads 1 from the next cycle until the commit.
- R3: A held write commits on a cycle where `sec_tick_i` is high if the committed prescaler bit is 1, and on a cycle where `raw_tick_i` is high if the bit is 0. The other strobe has no effect.
- R4: A synced-register write issued while a write is pending is discarded. This also holds in the cycle in which the pending write commits.
- R5: In the cycle after a commit, the new value is visible, status bit 14 reads 0 and status bit 15 reads 1. `time_load_o` is high for exactly that one cycle when the commit was to the time register.
- R6: A write to address 0 clears, in the next cycle, every status bit in positions 0..6 and 15 for which the data bit is 1. A set of the same bit in the same cycle wins over the clear. Bit 14 cannot be cleared by the host.
- R7: A high bit k of `event_i` (bit 0 stopwatch, 1 alarm, 2 second, 3 minute, 4 hour, 5 day rollover, 6 day alarm) sets status bit k in the next cycle, regardless of the enable register.
- R8: `irq_o` is high in cycle n+1 exactly when, in cycle n, some bit in positions 0..6 or 15 is 1 in both status and enable. Enable bit 14 and all enable bits other than 0..6 and 15 are stored as 0.
- R9: Writes to addresses 5..7 change no state, and reads from them return 0.
- R10: The read data is combinational on `addr_i`. Address 0 returns status, with bit 14 reflecting the pending write. Address 1 returns enable, 2 time, 3 alarm, and 4 the prescaler bit in bit 0. All results are zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | DATA_W | Host write data |
| rdata_o | output | DATA_W | Read data for `addr_i` |
| sec_tick_i | input | 1 | One-per-second tick strobe, host-synchronous |
| raw_tick_i | input | 1 | Raw oscillator tick strobe, host-synchronous |
| event_i | input | 7 | Event pulses from the time-keeping core |
| irq_o | output | 1 | Interrupt request |
| time_o | output | DATA_W | Committed time value |
| time_load_o | output | 1 | One-cycle pulse when a time write commits |
| alarm_o | output | DATA_W | Committed alarm value |
| presc_en_o | output | 1 | Committed prescaler enable |

## Verification
The bench uses the default 32-bit data width. This makes the full time and alarm words observable, and it places status bits 14 and 15 inside the zero-extended read word. The two tick strobes are driven as independent pulses. This brings within reach the switch-over from raw to second ticks after a prescaler commit. It also covers the tick-coincident dropped write, the same-cycle event-and-clear case, and an interrupt raised by write completion alone.

// File: rtl/rtc_wr_pkg.sv
package rtc_wr_pkg;
  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned STAT_W   = 16;
  localparam int unsigned EVT_W    = 7;
  localparam int unsigned BIT_PEND = 14;
  localparam int unsigned BIT_DONE = 15;
  // status/enable bits that carry an event or completion flag
  localparam logic [STAT_W-1:0] STAT_MASK = 16'h807F;

  typedef enum logic [ADDR_W-1:0] {
    REG_STAT  = 3'd0,
    REG_INTEN = 3'd1,
    REG_TIME  = 3'd2,
    REG_ALARM = 3'd3,
    REG_PRESC = 3'd4
  } reg_sel_e;

  function automatic logic is_synced(logic [ADDR_W-1:0] a);
    return (a == REG_INTEN) || (a == REG_TIME) || (a == REG_ALARM) || (a == REG_PRESC);
  endfunction
endpackage

// File: rtl/rtc_commit_stage.sv
module rtc_commit_stage
  import rtc_wr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              tick_i,
  output logic              pend_o,
  output logic              fire_o,
  output logic [ADDR_W-1:0] sel_o,
  output logic [DATA_W-1:0] data_o
);
  logic              pend_q;
  logic [ADDR_W-1:0] sel_q;
  logic [DATA_W-1:0] data_q;
  logic              fire;
  logic              accept;

  assign fire   = pend_q & tick_i;
  assign accept = wr_en_i & is_synced(addr_i) & ~pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      sel_q  <= '0;
      data_q <= '0;
    end else if (fire) begin
      pend_q <= 1'b0;
    end else if (accept) begin
      pend_q <= 1'b1;
      sel_q  <= addr_i;
      data_q <= wdata_i;
    end
  end

  assign pend_o = pend_q;
  assign fire_o = fire;
  assign sel_o  = sel_q;
  assign data_o = data_q;

  // R4: held write is never overwritten while outstanding
  p_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |=> $stable(data_q) && $stable(sel_q));
  // R5: commit retires the pending flag
  p_retire_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && tick_i) |=> !pend_q);
  // R2: accepted write raises pending
  p_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_q && wr_en_i && is_synced(addr_i)) |=> pend_q);
endmodule

// File: rtl/rtc_status_unit.sv
module rtc_status_unit
  import rtc_wr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_we_i,
  input  logic [STAT_W-1:0] clr_data_i,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic              done_i,
  input  logic [STAT_W-1:0] en_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              irq_o
);
  localparam int unsigned GAP_W = BIT_DONE - EVT_W;

  logic [STAT_W-1:0] stat_q;
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] clr_vec;
  logic              irq_q;

  assign set_vec = {done_i, {GAP_W{1'b0}}, evt_i};
  assign clr_vec = clr_we_i ? (clr_data_i & STAT_MASK) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~clr_vec) | set_vec;
      irq_q  <= |(stat_q & en_i & STAT_MASK);
    end
  end

  assign stat_o = stat_q;
  assign irq_o  = irq_q;

  // R6: cleared bits not re-set in the same cycle read 0 next cycle
  p_w1c_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && ((clr_data_i & STAT_MASK & ~set_vec) != '0))
      |=> ((stat_q & $past(clr_data_i & STAT_MASK & ~set_vec)) == '0));
  // R7: events land regardless of enable
  p_evt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((stat_q[EVT_W-1:0] & $past(evt_i)) == $past(evt_i)));
  // R8: interrupt only follows a set status bit
  p_irq_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(stat_q & STAT_MASK) != '0));
  // R5: completion sets bit 15
  p_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> stat_q[BIT_DONE]);
endmodule

// File: rtl/rtc_sync_regs.sv
module rtc_sync_regs
  import rtc_wr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              sec_tick_i,
  input  logic              raw_tick_i,
  input  logic [6:0]        event_i,
  output logic              irq_o,
  output logic [DATA_W-1:0] time_o,
  output logic              time_load_o,
  output logic [DATA_W-1:0] alarm_o,
  output logic              presc_en_o
);
  logic              pend;
  logic              fire;
  logic [ADDR_W-1:0] sel;
  logic [DATA_W-1:0] hold;
  logic              commit_tick;

  logic [DATA_W-1:0] time_q;
  logic [DATA_W-1:0] alarm_q;
  logic [STAT_W-1:0] en_q;
  logic              presc_q;
  logic              load_q;
  logic [STAT_W-1:0] stat;
  logic              stat_clr;

  assign commit_tick = presc_q ? sec_tick_i : raw_tick_i;
  assign stat_clr    = wr_en_i && (addr_i == REG_STAT);

  rtc_commit_stage #(.DATA_W(DATA_W)) u_commit (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .tick_i  (commit_tick),
    .pend_o  (pend),
    .fire_o  (fire),
    .sel_o   (sel),
    .data_o  (hold)
  );

  rtc_status_unit u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_we_i   (stat_clr),
    .clr_data_i (wdata_i[STAT_W-1:0]),
    .evt_i      (event_i),
    .done_i     (fire),
    .en_i       (en_q),
    .stat_o     (stat),
    .irq_o      (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_q  <= '0;
      alarm_q <= '0;
      en_q    <= '0;
      presc_q <= 1'b0;
      load_q  <= 1'b0;
    end else begin
      load_q <= fire && (sel == REG_TIME);
      if (fire) begin
        case (reg_sel_e'(sel))
          REG_INTEN: en_q    <= hold[STAT_W-1:0] & STAT_MASK;
          REG_TIME:  time_q  <= hold;
          REG_ALARM: alarm_q <= hold;
          REG_PRESC: presc_q <= hold[0];
          default:   ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_STAT:  rdata_o = DATA_W'(stat | (STAT_W'(pend) << BIT_PEND));
      REG_INTEN: rdata_o = DATA_W'(en_q);
      REG_TIME:  rdata_o = time_q;
      REG_ALARM: rdata_o = alarm_q;
      REG_PRESC: rdata_o = DATA_W'(presc_q);
      default:   rdata_o = '0;
    endcase
  end

  assign time_o      = time_q;
  assign alarm_o     = alarm_q;
  assign presc_en_o  = presc_q;
  assign time_load_o = load_q;

  // R2: register outputs hold while a write waits for its tick
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend && !commit_tick) |=> ($stable(time_q) && $stable(alarm_q) && $stable(en_q) && $stable(presc_q)));
  // R5: load pulse only after a commit
  p_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_load_o |-> $past(fire));
  // R8: bit 14 never enabled
  p_en14_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q[BIT_PEND]);
endmodule

// File: tb/sim_rtc_sync_regs.sv
module sim_rtc_sync_regs;
  localparam int CLK_P = 10;
  localparam int DW = 32;
  localparam logic [15:0] MASK = 16'h807F;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic sec_tick_i = 1'b0, raw_tick_i = 1'b0;
  logic [6:0] event_i = '0;
  logic irq_o, time_load_o, presc_en_o;
  logic [DW-1:0] time_o, alarm_o;

  int vectors = 0;
  int errs = 0;

  // reference state
  logic [DW-1:0] m_time = '0, m_alarm = '0, m_pdata = '0;
  logic [15:0] m_en = '0, m_stat = '0;
  logic m_presc = 1'b0, m_pend = 1'b0, m_load = 1'b0, m_irq = 1'b0;
  logic [2:0] m_paddr = '0;

  always #(CLK_P/2) clk_i = ~clk_i;

  rtc_sync_regs #(.DATA_W(DW)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .sec_tick_i(sec_tick_i),
    .raw_tick_i(raw_tick_i), .event_i(event_i), .irq_o(irq_o),
    .time_o(time_o), .time_load_o(time_load_o), .alarm_o(alarm_o),
    .presc_en_o(presc_en_o));

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return DW'(m_stat | {1'b0, m_pend, 14'b0});
      3'd1: return DW'(m_en);
      3'd2: return m_time;
      3'd3: return m_alarm;
      3'd4: return DW'(m_presc);
      default: return '0;
    endcase
  endfunction

  task automatic model_step;
    logic tick, fire;
    logic [15:0] clr, setv, old_stat;
    tick = m_presc ? sec_tick_i : raw_tick_i;
    fire = m_pend && tick;
    old_stat = m_stat;
    m_irq = |(old_stat & m_en & MASK);
    m_load = fire && (m_paddr == 3'd2);
    if (fire) begin
      case (m_paddr)
        3'd1: m_en = wdata_i[15:0] & 16'h0 | (m_pdata[15:0] & MASK);
        3'd2: m_time = m_pdata;
        3'd3: m_alarm = m_pdata;
        3'd4: m_presc = m_pdata[0];
        default: ;
      endcase
      m_pend = 1'b0;
    end else if (wr_en_i && addr_i >= 3'd1 && addr_i <= 3'd4 && !m_pend) begin
      m_pend = 1'b1;
      m_paddr = addr_i;
      m_pdata = wdata_i;
    end
    clr = (wr_en_i && addr_i == 3'd0) ? (wdata_i[15:0] & MASK) : 16'h0;
    setv = {fire, 8'b0, event_i};
    m_stat = (old_stat & ~clr) | setv;
  endtask

  task automatic compare;
    string rtag;
    rtag = (addr_i == 3'd0) ? "R6" : (addr_i > 3'd4) ? "R9" : "R10";
    chk(rtag, rdata_o, m_read(addr_i));
    chk("R2", time_o, m_time);
    chk("R2", alarm_o, m_alarm);
    chk("R3", DW'(presc_en_o), DW'(m_presc));
    chk("R5", DW'(time_load_o), DW'(m_load));
    chk("R8", DW'(irq_o), DW'(m_irq));
  endtask

  task automatic step;
    model_step();
    @(posedge clk_i);
    @(negedge clk_i);
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    step();
    wr_en_i = 1'b0;
  endtask

  task automatic raw_pulse;
    raw_tick_i = 1'b1; step(); raw_tick_i = 1'b0;
  endtask

  task automatic sec_pulse;
    sec_tick_i = 1'b1; step(); sec_tick_i = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [DW-1:0] exp);
    addr_i = a;
    #1;
    chk(tag, rdata_o, exp);
  endtask

  initial begin
    #(CLK_P * 200000);
    errs++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    @(negedge clk_i);
    // R1: reset state
    for (int a = 0; a < 5; a++) rd_chk("R1", 3'(a), '0);
    chk("R1", DW'({irq_o, time_load_o, presc_en_o}), '0);
    rst_ni = 1'b1;
    idle(2);

    // R2: time write held until raw tick (prescaler off)
    wr(3'd2, 32'h0001_2345);
    rd_chk("R2", 3'd0, 32'h0000_4000);
    idle(3);
    sec_pulse();                       // R3: wrong strobe, no commit
    chk("R3", time_o, 32'h0);
    raw_pulse();                       // commit
    chk("R5", time_o, 32'h0001_2345);
    rd_chk("R5", 3'd0, 32'h0000_8000);
    idle(1);

    // R4: second write while pending is dropped
    wr(3'd3, 32'hAAAA_0001);
    wr(3'd3, 32'hBBBB_0002);
    raw_pulse();
    idle(1);
    chk("R4", alarm_o, 32'hAAAA_0001);

    // R6: clear completion flag
    wr(3'd0, 32'h0000_8000);
    rd_chk("R6", 3'd0, 32'h0);

    // R3: enable prescaler, then commits follow the second tick
    wr(3'd4, 32'h1);
    raw_pulse();
    idle(1);
    chk("R3", DW'(presc_en_o), 32'h1);
    wr(3'd2, 32'h0000_0777);
    raw_pulse();
    idle(2);
    chk("R3", time_o, 32'h0001_2345);
    sec_pulse();
    idle(1);
    chk("R3", time_o, 32'h0000_0777);

    // R4: write in the same cycle as the commit is dropped
    wr(3'd3, 32'h1111_1111);
    sec_tick_i = 1'b1;
    wr(3'd3, 32'h2222_2222);
    sec_tick_i = 1'b0;
    idle(1);
    rd_chk("R4", 3'd0, 32'h0000_8000);
    chk("R4", alarm_o, 32'h1111_1111);
    wr(3'd0, 32'hFFFF_FFFF);

    // R7: events set status with no enable, no interrupt
    event_i = 7'h55; step(); event_i = '0;
    idle(2);
    rd_chk("R7", 3'd0, 32'h0000_0055);
    chk("R8", DW'(irq_o), 32'h0);

    // R8: enable write with bit 14 set; interrupt follows status & enable
    wr(3'd1, 32'hFFFF_4004);
    sec_pulse();
    idle(3);
    rd_chk("R8", 3'd1, 32'h0000_0004);
    wr(3'd0, 32'h0000_8000);
    idle(1);
    wr(3'd0, 32'h0000_0004);
    idle(3);
    chk("R8", DW'(irq_o), 32'h0);

    // R6: set wins over clear in the same cycle
    event_i = 7'h04; wr_en_i = 1'b1; addr_i = 3'd0; wdata_i = 32'h4;
    step();
    event_i = '0; wr_en_i = 1'b0;
    idle(2);

    // R8: completion alone raises interrupt when enabled
    wr(3'd1, 32'h0000_8000);
    sec_pulse();
    idle(3);
    wr(3'd0, 32'h0000_C07F);         // R6: bit 14 write has no effect
    idle(2);

    // R9: unmapped addresses
    for (int a = 5; a < 8; a++) wr(3'(a), 32'hDEAD_BEEF);
    idle(2);
    rd_chk("R9", 3'd0, 32'h0);
    for (int a = 5; a < 8; a++) rd_chk("R9", 3'(a), '0);
    rd_chk("R10", 3'd4, 32'h1);

    // mixed stimulus
    for (int i = 0; i < 200; i++) begin
      wr_en_i = (i % 3) == 0;
      addr_i = 3'(i % 6);
      wdata_i = 32'(i * 32'h0101_0107);
      raw_tick_i = (i % 5) == 0;
      sec_tick_i = (i % 7) == 0;
      event_i = 7'(i * 13) & 7'h7F;
      step();
    end
    wr_en_i = 1'b0; raw_tick_i = 1'b0; sec_tick_i = 1'b0; event_i = '0;
    idle(3);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule